// File: doc/BRIEF.md
# Register write-apply status tracker

This block carries register writes from a fast bus clock domain into a slower timer clock domain. For each register it tracks, it keeps a sticky status bit that the bus can read. Each bus write to a tracked register is captured and sent across. When the timer domain has loaded the value, the tracker sets that register's status bit. Software polls the bit, which stays set until software clears it by writing a one to its position in the status word.

The tracked registers fall into three groups, and each group has its own status word. The global group holds the control word, the comparator low and high words and the auto-increment step. The counter group holds the counter low and high words. The per-core group holds the tick count buffer, the interrupt count buffer and the local control word.

Each register crosses on its own toggle channel, with a two-flop synchronizer in each direction. In the timer domain, every loaded value comes out on a flat value bus together with a one-cycle update strobe.

Top module: `wr_apply_tracker`

## Requirements
- R1: A bus write to a tracked register appears on that register's slice of `tmr_value`, together with a one-cycle `tmr_update` pulse. Slices follow register index order: 0 global control (addr 0x00), 1 comparator low (0x01), 2 comparator high (0x02), 3 auto-increment (0x03), 4 counter low (0x04), 5 counter high (0x05), 6 tick count buffer (0x08), 7 interrupt count buffer (0x09), 8 local control (0x0A).
- R2: A register's status bit rises only after the timer domain holds the written value.
- R3: The global status word is read at address 0x10. Bit 0 is comparator low, bit 1 is comparator high, bit 2 is auto-increment and bit 16 is global control. All other bits read zero.
- R4: The counter status word is read at address 0x11. Bit 0 is counter low and bit 1 is counter high. All other bits read zero.
- R5: The per-core status word is read at address 0x12. Bit 0 is the tick count buffer, bit 1 is the interrupt count buffer and bit 3 is local control. All other bits read zero.
- R6: Writing a status word clears exactly the bits written as one. Bits written as zero keep their value.
- R7: If a clear and a new apply event reach the same bit in the same bus cycle, the bit ends up set.
- R8: A write to an address outside the tracked set and outside the status words changes no status bit and no timer-domain value.
- R9: A write to a register whose previous transfer is still in flight is dropped. The first value stays the applied one.
- R10: After reset, every status bit and every timer-domain value is zero.
- R11: A status bit stays set across idle cycles and reads until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| bus_rst_n | input | 1 | Bus-side active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | DATA_W | Bus write data |
| rd_addr | input | ADDR_W | Status word read address |
| rd_data | output | DATA_W | Selected status word (combinational) |
| tmr_clk | input | 1 | Timer-domain clock |
| tmr_rst_n | input | 1 | Timer-domain active-low reset |
| tmr_value | output | NREG*DATA_W | Applied register values, index order |
| tmr_update | output | NREG | One-cycle load strobe per register |

## Verification
Assertions are checked on every cycle. They cover the following:
- A status bit rises only after an acknowledge edge.
- An acknowledge edge forces its bit set even against a clear.
- A set bit holds unless it is cleared.
- A write to a busy channel or to an untracked address leaves the request toggles and held data untouched.
- A timer-domain value changes only with its update strobe.

Some properties span both clock domains, and only the bench scenarios can show them. These are that the value is present before the status bit rises, that the bit layout of the three status words is correct, and that a second write in flight is really lost.

// File: rtl/wat_pkg.sv
package wat_pkg;

    localparam int NREG = 9;

    typedef enum logic [1:0] {
        GRP_GLOBAL  = 2'd0,
        GRP_COUNTER = 2'd1,
        GRP_CORE    = 2'd2
    } grp_e;

    // bus address of each tracked register, by index
    function automatic int reg_addr(input int idx);
        case (idx)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 3;
            4: return 4;
            5: return 5;
            6: return 8;
            7: return 9;
            default: return 10;
        endcase
    endfunction

    function automatic grp_e reg_group(input int idx);
        if (idx < 4) return GRP_GLOBAL;
        else if (idx < 6) return GRP_COUNTER;
        else return GRP_CORE;
    endfunction

    // position of a register's bit inside its group's status word
    function automatic int reg_bit(input int idx);
        case (idx)
            0: return 16;
            1: return 0;
            2: return 1;
            3: return 2;
            4: return 0;
            5: return 1;
            6: return 0;
            7: return 1;
            default: return 3;
        endcase
    endfunction

    localparam int STAT_BASE = 16;

    function automatic int stat_addr(input grp_e g);
        return STAT_BASE + int'(g);
    endfunction

endpackage

// File: rtl/wat_sync2.sv
module wat_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/wat_chan_src.sv
module wat_chan_src #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [DW-1:0] wr_data,
    input  logic          ack_async,
    output logic          req_out,
    output logic [DW-1:0] data_out,
    output logic          ack_evt
);
    typedef struct packed {
        logic          req;
        logic          ack_last;
        logic [DW-1:0] hold;
    } st_t;

    st_t  st_d, st_q;
    logic ack_s;
    logic busy;

    wat_sync2 #(.W(1)) u_ack_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ack_async),
        .sync_out (ack_s)
    );

    always_comb begin
        st_d        = st_q;
        busy        = st_q.req != st_q.ack_last;
        ack_evt     = ack_s != st_q.ack_last;
        st_d.ack_last = ack_s;
        if (wr_hit && !busy) begin
            st_d.hold = wr_data;
            st_d.req  = ~st_q.req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_out  = st_q.req;
    assign data_out = st_q.hold;

    // R2: an acknowledge edge only comes back for a transfer in flight
    assert_ack_when_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_evt |-> (st_q.req != st_q.ack_last));

    // R9: a write to a busy channel leaves request and held data alone
    assert_busy_write_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && (st_q.req != st_q.ack_last)) |=> ($stable(st_q.hold) && $stable(st_q.req)));
endmodule

// File: rtl/wat_chan_dst.sv
module wat_chan_dst #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_async,
    input  logic [DW-1:0] data_async,
    output logic [DW-1:0] val_out,
    output logic          upd_out,
    output logic          ack_out
);
    typedef struct packed {
        logic          ack;
        logic          upd;
        logic [DW-1:0] val;
    } st_t;

    st_t  st_d, st_q;
    logic req_s;

    wat_sync2 #(.W(1)) u_req_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (req_async),
        .sync_out (req_s)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (req_s != st_q.ack) begin
            // held data has been stable since the request toggled
            st_d.val = data_async;
            st_d.ack = req_s;
            st_d.upd = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_out = st_q.val;
    assign upd_out = st_q.upd;
    assign ack_out = st_q.ack;

    // R1: the applied value changes only together with its update strobe
    assert_value_with_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (val_out != $past(val_out)) |-> upd_out);
endmodule

// File: rtl/wr_apply_tracker.sv
module wr_apply_tracker
    import wat_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                   bus_clk,
    input  logic                   bus_rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [DATA_W-1:0]      rd_data,
    input  logic                   tmr_clk,
    input  logic                   tmr_rst_n,
    output logic [NREG*DATA_W-1:0] tmr_value,
    output logic [NREG-1:0]        tmr_update
);
    typedef struct packed {
        logic [NREG-1:0] stat;
    } st_t;

    st_t st_d, st_q;

    logic [NREG-1:0]        hit;
    logic [NREG-1:0]        clr;
    logic [NREG-1:0]        ack_evt;
    logic [NREG-1:0]        req;
    logic [NREG-1:0]        ack;
    logic [DATA_W-1:0]      xfer_data [NREG];
    logic [DATA_W-1:0]      rd_part   [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_chan
        localparam logic [ADDR_W-1:0] RegA  = ADDR_W'(reg_addr(i));
        localparam logic [ADDR_W-1:0] StatA = ADDR_W'(stat_addr(reg_group(i)));
        localparam int                BitP  = reg_bit(i);

        assign hit[i]     = wr_en && (wr_addr == RegA);
        assign clr[i]     = wr_en && (wr_addr == StatA) && wr_data[BitP];
        assign rd_part[i] = (rd_addr == StatA) ? (DATA_W'(st_q.stat[i]) << BitP) : '0;

        wat_chan_src #(.DW(DATA_W)) u_src (
            .clk       (bus_clk),
            .rst_n     (bus_rst_n),
            .wr_hit    (hit[i]),
            .wr_data   (wr_data),
            .ack_async (ack[i]),
            .req_out   (req[i]),
            .data_out  (xfer_data[i]),
            .ack_evt   (ack_evt[i])
        );

        wat_chan_dst #(.DW(DATA_W)) u_dst (
            .clk        (tmr_clk),
            .rst_n      (tmr_rst_n),
            .req_async  (req[i]),
            .data_async (xfer_data[i]),
            .val_out    (tmr_value[i*DATA_W +: DATA_W]),
            .upd_out    (tmr_update[i]),
            .ack_out    (ack[i])
        );

        // R7: an apply event leaves the bit set, whatever the clear says
        assert_set_wins_R7: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
            ack_evt[i] |=> st_q.stat[i]);

        // R11: a set bit holds unless a clear names it
        assert_sticky_R11: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
            (st_q.stat[i] && !clr[i]) |=> st_q.stat[i]);

        // R2: a bit rises only after an acknowledge edge
        assert_rise_after_ack_R2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
            $rose(st_q.stat[i]) |-> $past(ack_evt[i]));
    end

    always_comb begin
        st_d      = st_q;
        st_d.stat = (st_q.stat & ~clr) | ack_evt;
    end

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) rd_data = rd_data | rd_part[i];
    end

    // R8: a write outside the tracked set starts no transfer
    assert_untracked_quiet_R8: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (wr_en && (hit == '0)) |=> $stable(req));
endmodule

// File: tb/sim_wr_apply_tracker.sv
module sim_wr_apply_tracker;
    localparam int DW = 32;
    localparam int AW = 5;
    localparam int N  = 9;
    localparam int TIMEOUT = 40;

    logic          bus_clk = 0;
    logic          tmr_clk = 0;
    logic          rst_n = 0;
    logic          wr_en = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [N*DW-1:0] tmr_value;
    logic [N-1:0]    tmr_update;

    always #5 bus_clk = ~bus_clk;
    initial begin
        #3;
        forever #18.5 tmr_clk = ~tmr_clk;
    end

    wr_apply_tracker #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .bus_clk(bus_clk), .bus_rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tmr_clk(tmr_clk), .tmr_rst_n(rst_n), .tmr_value(tmr_value),
        .tmr_update(tmr_update)
    );

    int checks = 0;
    int errors = 0;
    string tag = "R10";

    // reference model
    bit          exp_bit [N];
    bit          pend    [N];
    int          pend_cnt[N];
    logic [DW-1:0] exp_val[N];
    logic [DW-1:0] cur_val[N];

    function automatic int m_addr(int i);
        int a [N] = '{0, 1, 2, 3, 4, 5, 8, 9, 10};
        return a[i];
    endfunction
    function automatic int m_word(int i);
        return (i <= 3) ? 0 : (i <= 5) ? 1 : 2;
    endfunction
    function automatic int m_pos(int i);
        int p [N] = '{16, 0, 1, 2, 0, 1, 0, 1, 3};
        return p[i];
    endfunction

    task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [DW-1:0] w [3];
        logic [DW-1:0] used [3];
        for (int g = 0; g < 3; g++) begin
            rd_addr = AW'(16 + g);
            #1;
            w[g] = rd_data;
            used[g] = '0;
        end
        for (int i = 0; i < N; i++) begin
            bit b;
            b = w[m_word(i)][m_pos(i)];
            used[m_word(i)][m_pos(i)] = 1'b1;
            if (pend[i]) begin
                if (b) begin
                    chk(tmr_value[i*DW +: DW] == exp_val[i], "R2 value before status",
                        tmr_value[i*DW +: DW], exp_val[i]);
                    pend[i] = 0; exp_bit[i] = 1; cur_val[i] = exp_val[i];
                end else begin
                    pend_cnt[i]++;
                    if (pend_cnt[i] > TIMEOUT) begin
                        chk(0, "R1 apply timeout", 0, 1);
                        pend[i] = 0; exp_bit[i] = 1; cur_val[i] = exp_val[i];
                    end
                end
            end else begin
                chk(b == exp_bit[i], tag, DW'(b), DW'(exp_bit[i]));
                chk(tmr_value[i*DW +: DW] == cur_val[i], tag, tmr_value[i*DW +: DW], cur_val[i]);
            end
        end
        // R3 R4 R5: unassigned status bits read zero
        for (int g = 0; g < 3; g++)
            chk((w[g] & ~used[g]) == '0, "R3/R4/R5 spare bits", w[g] & ~used[g], '0);
    endtask

    task automatic tick();
        @(posedge bus_clk);
        @(negedge bus_clk);
        wr_en = 0;
        compare();
    endtask

    task automatic bus_write(int a, logic [DW-1:0] d);
        wr_en = 1; wr_addr = AW'(a); wr_data = d;
        for (int i = 0; i < N; i++) begin
            if (a == m_addr(i) && !pend[i]) begin
                pend[i] = 1; pend_cnt[i] = 0; exp_val[i] = d;
            end
            if (a == 16 + m_word(i) && d[m_pos(i)] && !pend[i]) exp_bit[i] = 0;
        end
        tick();
    endtask

    task automatic settle(int i);
        while (pend[i]) tick();
    endtask

    initial begin
        repeat (2000000) @(posedge bus_clk);
        chk(0, "R1 watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            exp_bit[i] = 0; pend[i] = 0; pend_cnt[i] = 0; exp_val[i] = '0; cur_val[i] = '0;
        end
        @(negedge bus_clk);
        tag = "R10";
        repeat (4) begin @(negedge bus_clk); compare(); end
        rst_n = 1;
        repeat (6) tick();

        // R1, R3: global group one at a time
        tag = "R3";
        for (int i = 0; i < 4; i++) begin
            bus_write(m_addr(i), 32'hA000_0000 + DW'(i * 17 + 5));
            settle(i);
        end
        // R1, R4: counter group back to back
        tag = "R4";
        bus_write(m_addr(4), 32'h1234_5678);
        bus_write(m_addr(5), 32'h9ABC_DEF0);
        settle(4); settle(5);
        // R1, R5: per-core group
        tag = "R5";
        for (int i = 6; i < N; i++) begin
            bus_write(m_addr(i), 32'h0F0F_0000 | DW'(i));
        end
        for (int i = 6; i < N; i++) settle(i);
        tag = "R1";
        repeat (5) tick();

        // R11: bits hold across idle cycles and reads
        tag = "R11";
        repeat (20) tick();

        // R6: clear one bit, zero-mask write, then clear the rest
        tag = "R6";
        bus_write(16, 32'h0000_0002);
        bus_write(17, 32'h0000_0000);
        bus_write(18, 32'h0000_0008);
        bus_write(16, 32'hFFFF_FFFF);
        bus_write(17, 32'hFFFF_FFFF);
        bus_write(18, 32'hFFFF_FFFF);
        repeat (3) tick();

        // R8: untracked addresses change nothing
        tag = "R8";
        bus_write(6, 32'hDEAD_BEEF);
        bus_write(7, 32'hDEAD_BEEF);
        bus_write(11, 32'hDEAD_BEEF);
        bus_write(15, 32'hDEAD_BEEF);
        bus_write(19, 32'hFFFF_FFFF);
        bus_write(31, 32'hFFFF_FFFF);
        repeat (30) tick();

        // R9: second write while first is in flight is lost
        tag = "R9";
        bus_write(m_addr(2), 32'h1111_1111);
        bus_write(m_addr(2), 32'h2222_2222);
        settle(2);
        repeat (30) tick();

        // R7: clear held every cycle while the apply lands
        tag = "R7";
        bus_write(m_addr(3), 32'h0000_0777);
        while (pend[3]) bus_write(16, 32'h0000_0004);
        repeat (3) tick();
        bus_write(16, 32'h0000_0004);
        repeat (3) tick();

        // R2: rewrite a counter word, status must follow the value
        tag = "R2";
        bus_write(m_addr(4), 32'h0BAD_F00D);
        settle(4);
        repeat (10) tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule